// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block keeps a small number of recently used page-table entries close to the address path. A client presents a virtual page number (VPN) and receives, in the same cycle, either a hit together with the cached page-table entry or a miss. A miss means the entry has to be fetched from the in-memory page table by some other agent. When that entry arrives it is written back through the fill port.

The VPN is split into two fields. Its low bits, which sit just above the page offset in the full virtual address, choose one of the sets. The remaining upper bits are the tag, which is compared with every valid way of that set in parallel. Each line carries a valid flag, its tag and the full page-table entry as payload. A fill picks its way in this order:
- a way that already holds the same VPN;
- otherwise the lowest free way;
- otherwise the way named by a round-robin pointer that each set keeps for itself.

A single flush input drops every entry at once, for instance after an address-space switch.

Top module: `xlate_tlb`

## Requirements
- R1: The set index is `lookupVpn[IDX_W-1:0]` (the same slice of `fillVpn` for fills), with IDX_W = log2(SETS). The tag is the rest of the VPN above it. Up to WAYS entries whose VPNs differ only in their tag are held in one set at the same time.
- R2: The lookup is combinational. While `lookupEn` is high, `lookupHit` and `lookupPte` reflect, in the same cycle, the entry most recently filled for `lookupVpn`.
- R3: With `lookupEn` high and no valid matching way, `lookupMiss` is 1 and `lookupHit` is 0. With `lookupEn` low, both are 0. Whenever `lookupHit` is 0, `lookupPte` is all zeros.
- R4: A fill becomes visible to lookups from the cycle after `fillEn` is sampled. A lookup in the fill cycle sees the earlier contents.
- R5: A fill whose VPN is already cached overwrites that way's entry in place. It creates no second copy, leaves the other ways of the set unchanged and does not move the round-robin pointer.
- R6: A fill into a set that has a free way writes the lowest-numbered free way and evicts nothing.
- R7: A fill of a new VPN into a full set replaces the way named by that set's round-robin pointer. The pointer is 0 after reset and advances by one, wrapping from WAYS-1 to 0, after each such replacement only. Every set has its own pointer.
- R8: `flushAll` invalidates every entry in one cycle. A lookup in that cycle reports a miss, and a fill in that cycle is dropped. The round-robin pointers keep their values.
- R9: After reset every entry is invalid, so every lookup misses.
- R10: A lookup never changes the stored state. Repeating the same lookup with no fill or flush in between gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lookupEn | input | 1 | Lookup request this cycle |
| lookupVpn | input | VPN_W | VPN to translate |
| lookupHit | output | 1 | Matching valid entry found |
| lookupMiss | output | 1 | Lookup requested, no valid entry |
| lookupPte | output | PTE_W | Cached entry on a hit, zero otherwise |
| fillEn | input | 1 | Write an entry this cycle |
| fillVpn | input | VPN_W | VPN of the entry being written |
| fillPte | input | PTE_W | Page-table entry being written |
| flushAll | input | 1 | Invalidate every entry |

## Verification
The assertions take for granted that all inputs carry known values whenever reset is released. They also assume that entries only ever enter through the fill port, so the property that at most one way of a set matches depends on the fill-side duplicate check and not on anything the client promises. The stimulus drives every input at every cycle, reset included, and draws tags from a pool of six values per set. That pool makes duplicate fills, full sets and evictions frequent, so the single-match property and the round-robin order are exercised heavily.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
  // Strobes from the control block to the storage block
  typedef struct packed {
    logic wrEn;   // write the selected way of the fill set
    logic clrAll; // clear every valid flag
  } tlbStrobe_t;
endpackage

// File: rtl/xtlb_data.sv
module xtlb_data
  import xtlb_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int VPN_W = 20,
  parameter int PTE_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [VPN_W-1:0]       lookupVpn,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [PTE_W-1:0]       fillPte,
  input  tlbStrobe_t             strobe,
  input  logic [$clog2(WAYS)-1:0] fillWay,
  output logic [WAYS-1:0]        lookupMatch,
  output logic [PTE_W-1:0]       lookupPteRaw,
  output logic [WAYS-1:0]        fillSetValid,
  output logic [WAYS-1:0]        fillMatch
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0]  validQ [SETS];
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];
  logic [PTE_W-1:0] pteQ   [SETS][WAYS];

  logic [IDX_W-1:0] lkIdx, flIdx;
  logic [TAG_W-1:0] lkTag, flTag;

  assign lkIdx = lookupVpn[IDX_W-1:0];
  assign lkTag = lookupVpn[VPN_W-1:IDX_W];
  assign flIdx = fillVpn[IDX_W-1:0];
  assign flTag = fillVpn[VPN_W-1:IDX_W];

  // Parallel tag compare: one bank for lookups, one for fills
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lookupMatch[w] = validQ[lkIdx][w] && (tagQ[lkIdx][w] == lkTag);
    assign fillMatch[w]   = validQ[flIdx][w] && (tagQ[flIdx][w] == flTag);
  end

  assign fillSetValid = validQ[flIdx];

  // At most one way matches, so an OR of gated payloads is the mux
  always_comb begin
    lookupPteRaw = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lookupMatch[w]) lookupPteRaw = lookupPteRaw | pteQ[lkIdx][w];
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n || strobe.clrAll) begin
        validQ[s] <= '0;
      end else if (strobe.wrEn && flIdx == IDX_W'(s)) begin
        validQ[s][fillWay] <= 1'b1;
      end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
      always_ff @(posedge clk) begin
        if (strobe.wrEn && flIdx == IDX_W'(s) && fillWay == WAY_W'(w)) begin
          tagQ[s][w] <= flTag;
          pteQ[s][w] <= fillPte;
        end
      end
    end
  end
endmodule

// File: rtl/xtlb_ctrl.sv
module xtlb_ctrl
  import xtlb_pkg::*;
#(
  parameter int SETS = 4,
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fillEn,
  input  logic                    flushAll,
  input  logic [$clog2(SETS)-1:0] fillIdx,
  input  logic [WAYS-1:0]         fillSetValid,
  input  logic [WAYS-1:0]         fillMatch,
  output tlbStrobe_t              strobe,
  output logic [$clog2(WAYS)-1:0] fillWay
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] rrPtrQ [SETS];
  logic [WAY_W-1:0] freeWay, hitWay;
  logic             anyMatch, setFull, evict;

  // Priority encoders: lowest free way, the matching way
  always_comb begin
    freeWay = '0;
    hitWay  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!fillSetValid[w]) freeWay = WAY_W'(w);
      if (fillMatch[w])     hitWay  = WAY_W'(w);
    end
  end

  assign anyMatch = |fillMatch;
  assign setFull  = &fillSetValid;

  always_comb begin
    strobe.clrAll = flushAll;
    strobe.wrEn   = fillEn && !flushAll;
    if (anyMatch)      fillWay = hitWay;
    else if (!setFull) fillWay = freeWay;
    else               fillWay = rrPtrQ[fillIdx];
  end

  assign evict = strobe.wrEn && !anyMatch && setFull;

  for (genvar s = 0; s < SETS; s++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rrPtrQ[s] <= '0;
      end else if (evict && fillIdx == IDX_W'(s)) begin
        rrPtrQ[s] <= (rrPtrQ[s] == WAY_W'(WAYS - 1)) ? '0 : rrPtrQ[s] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import xtlb_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int VPN_W = 20,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookupEn,
  input  logic [VPN_W-1:0] lookupVpn,
  output logic             lookupHit,
  output logic             lookupMiss,
  output logic [PTE_W-1:0] lookupPte,
  input  logic             fillEn,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PTE_W-1:0] fillPte,
  input  logic             flushAll
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  tlbStrobe_t       strobe;
  logic [WAY_W-1:0] fillWay;
  logic [WAYS-1:0]  lookupMatch, fillSetValid, fillMatch;
  logic [PTE_W-1:0] lookupPteRaw;

  xtlb_ctrl #(.SETS(SETS), .WAYS(WAYS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fillEn(fillEn), .flushAll(flushAll),
    .fillIdx(fillVpn[IDX_W-1:0]), .fillSetValid(fillSetValid),
    .fillMatch(fillMatch), .strobe(strobe), .fillWay(fillWay)
  );

  xtlb_data #(.SETS(SETS), .WAYS(WAYS), .VPN_W(VPN_W), .PTE_W(PTE_W)) u_data (
    .clk(clk), .rst_n(rst_n), .lookupVpn(lookupVpn), .fillVpn(fillVpn),
    .fillPte(fillPte), .strobe(strobe), .fillWay(fillWay),
    .lookupMatch(lookupMatch), .lookupPteRaw(lookupPteRaw),
    .fillSetValid(fillSetValid), .fillMatch(fillMatch)
  );

  assign lookupHit  = lookupEn && !flushAll && (|lookupMatch);
  assign lookupMiss = lookupEn && !lookupHit;
  assign lookupPte  = lookupHit ? lookupPteRaw : '0;
endmodule

// File: rtl/xlate_tlb_chk.sv
module xlate_tlb_chk #(
  parameter int WAYS  = 4,
  parameter int VPN_W = 20,
  parameter int PTE_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lookupEn,
  input logic [VPN_W-1:0] lookupVpn,
  input logic             lookupHit,
  input logic [PTE_W-1:0] lookupPte,
  input logic             fillEn,
  input logic [VPN_W-1:0] fillVpn,
  input logic [PTE_W-1:0] fillPte,
  input logic             flushAll,
  input logic [WAYS-1:0]  lookupMatch
);
  // R5
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lookupMatch));

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flushAll |=> !lookupHit);

  // R4
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fillEn && !flushAll) |=>
      (!(lookupEn && !flushAll && lookupVpn == $past(fillVpn)) ||
       (lookupHit && lookupPte == $past(fillPte))));

  // R10
  lookup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupEn && $past(lookupEn) && $stable(lookupVpn) && !flushAll &&
     !$past(fillEn) && !$past(flushAll)) |->
      (lookupHit == $past(lookupHit) && lookupPte == $past(lookupPte)));
endmodule

bind xlate_tlb xlate_tlb_chk #(.WAYS(WAYS), .VPN_W(VPN_W), .PTE_W(PTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lookupEn(lookupEn), .lookupVpn(lookupVpn),
  .lookupHit(lookupHit), .lookupPte(lookupPte), .fillEn(fillEn),
  .fillVpn(fillVpn), .fillPte(fillPte), .flushAll(flushAll),
  .lookupMatch(lookupMatch)
);

// File: tb/xlate_tlb_tb.sv
module xlate_tlb_tb;
  localparam int SETS  = 4;
  localparam int WAYS  = 4;
  localparam int VPN_W = 20;
  localparam int PTE_W = 32;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lookupEn = 1'b0, fillEn = 1'b0, flushAll = 1'b0;
  logic [VPN_W-1:0] lookupVpn = '0, fillVpn = '0;
  logic [PTE_W-1:0] fillPte = '0;
  logic lookupHit, lookupMiss;
  logic [PTE_W-1:0] lookupPte;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Reference state
  logic             mValid [SETS][WAYS];
  logic [TAG_W-1:0] mTag   [SETS][WAYS];
  logic [PTE_W-1:0] mPte   [SETS][WAYS];
  int               mPtr   [SETS];

  always #4 clk = ~clk; // 125 MHz

  xlate_tlb #(.SETS(SETS), .WAYS(WAYS), .VPN_W(VPN_W), .PTE_W(PTE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .lookupEn(lookupEn), .lookupVpn(lookupVpn),
    .lookupHit(lookupHit), .lookupMiss(lookupMiss), .lookupPte(lookupPte),
    .fillEn(fillEn), .fillVpn(fillVpn), .fillPte(fillPte), .flushAll(flushAll)
  );

  function automatic logic [VPN_W-1:0] mkVpn(int tag, int idx);
    return {TAG_W'(tag), IDX_W'(idx)};
  endfunction

  // Expected {hit, pte} for the current reference state
  function automatic logic [PTE_W:0] expLookup(logic en, logic [VPN_W-1:0] v, logic fl);
    int s = int'(v[IDX_W-1:0]);
    if (!en || fl) return '0;
    for (int w = 0; w < WAYS; w++)
      if (mValid[s][w] && mTag[s][w] == v[VPN_W-1:IDX_W]) return {1'b1, mPte[s][w]};
    return '0;
  endfunction

  function automatic void modelUpdate(logic fe, logic [VPN_W-1:0] v, logic [PTE_W-1:0] p, logic fl);
    int s = int'(v[IDX_W-1:0]);
    int way = -1;
    if (fl) begin
      for (int a = 0; a < SETS; a++)
        for (int w = 0; w < WAYS; w++) mValid[a][w] = 1'b0;
      return;
    end
    if (!fe) return;
    for (int w = 0; w < WAYS; w++)
      if (way < 0 && mValid[s][w] && mTag[s][w] == v[VPN_W-1:IDX_W]) way = w;
    for (int w = 0; w < WAYS; w++)
      if (way < 0 && !mValid[s][w]) way = w;
    if (way < 0) begin
      way = mPtr[s];
      mPtr[s] = (mPtr[s] + 1) % WAYS;
    end
    mValid[s][way] = 1'b1;
    mTag[s][way]   = v[VPN_W-1:IDX_W];
    mPte[s][way]   = p;
  endfunction

  task automatic chk(logic ok, string req, logic [PTE_W:0] act, logic [PTE_W:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare before posedge, advance reference
  task automatic step(string req, logic le, logic [VPN_W-1:0] lv,
                      logic fe, logic [VPN_W-1:0] fv, logic [PTE_W-1:0] fp, logic fl);
    logic [PTE_W:0] exp;
    @(negedge clk);
    lookupEn = le; lookupVpn = lv; fillEn = fe; fillVpn = fv; fillPte = fp; flushAll = fl;
    #2;
    exp = expLookup(le, lv, fl);
    chk(lookupHit == exp[PTE_W] && lookupPte == exp[PTE_W-1:0] &&
        lookupMiss == (le && !exp[PTE_W]),
        req, {lookupHit, lookupPte}, exp);
    modelUpdate(fe, fv, fp, fl);
  endtask

  task automatic look(string req, logic [VPN_W-1:0] v);
    step(req, 1'b1, v, 1'b0, '0, '0, 1'b0);
  endtask

  task automatic fill(string req, logic [VPN_W-1:0] v, logic [PTE_W-1:0] p);
    step(req, 1'b0, '0, 1'b1, v, p, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_ed01));
    for (int a = 0; a < SETS; a++) begin
      mPtr[a] = 0;
      for (int w = 0; w < WAYS; w++) begin
        mValid[a][w] = 1'b0; mTag[a][w] = '0; mPte[a][w] = '0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9: empty after reset
    look("R9", mkVpn(1, 0));
    look("R9", mkVpn(0, 3));
    // R3: idle lookup gives neither hit nor miss
    step("R3", 1'b0, mkVpn(1, 0), 1'b0, '0, '0, 1'b0);

    // R1/R6: four tags share set 2
    for (int t = 1; t <= WAYS; t++) fill("R6", mkVpn(t, 2), 32'hA000 + t);
    for (int t = 1; t <= WAYS; t++) look("R1", mkVpn(t, 2));
    look("R1", mkVpn(1, 1));        // same tag, other set: miss
    // R4: fill and lookup of same VPN in one cycle sees old state
    step("R4", 1'b1, mkVpn(9, 0), 1'b1, mkVpn(9, 0), 32'h9999, 1'b0);
    look("R4", mkVpn(9, 0));
    // R5: overwrite in place, pointer untouched
    fill("R5", mkVpn(3, 2), 32'hBEEF);
    for (int t = 1; t <= WAYS; t++) look("R5", mkVpn(t, 2));
    // R7: evictions walk the ways in order
    fill("R7", mkVpn(7, 2), 32'h7777);
    look("R7", mkVpn(1, 2));        // way 0 gone
    look("R7", mkVpn(7, 2));
    fill("R7", mkVpn(8, 2), 32'h8888);
    look("R7", mkVpn(2, 2));        // way 1 gone
    look("R7", mkVpn(3, 2));
    // R8: flush with concurrent lookup and fill
    step("R8", 1'b1, mkVpn(7, 2), 1'b1, mkVpn(5, 1), 32'h5555, 1'b1);
    look("R8", mkVpn(5, 1));
    look("R8", mkVpn(8, 2));
    // R7: pointer kept across flush; set 2 refilled then evicts at way 2
    for (int t = 1; t <= WAYS; t++) fill("R7", mkVpn(t + 20, 2), 32'hC000 + t);
    fill("R7", mkVpn(30, 2), 32'hC030);
    look("R7", mkVpn(23, 2));
    look("R7", mkVpn(21, 2));
    look("R10", mkVpn(21, 2));

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic le = ($urandom_range(3) != 0);
      logic fe = ($urandom_range(2) == 0);
      logic fl = ($urandom_range(63) == 0);
      step("R2", le, mkVpn($urandom_range(5), $urandom_range(SETS - 1)),
           fe, mkVpn($urandom_range(5), $urandom_range(SETS - 1)), $urandom(), fl);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule